// File: doc/BRIEF.md
# Coprocessor Branch Resolution Unit

This combinational block decides where a small coprocessor goes after a branch instruction. It receives the current program counter, the 32-bit instruction word, the four-entry register file, the stage counter and the two flags kept from the last ALU operation. It returns the next program counter and a flag that says whether the branch was taken. Program counters count 32-bit words and are 11 bits wide by default, so every target wraps within that word space.

The block resolves three kinds of branch, chosen by the sub-opcode. The first is an absolute jump to an immediate address or to an address held in a register, which can be made conditional on the zero or overflow flag. The second is a relative branch that compares R0 with a 16-bit immediate. The third is a relative branch that compares the stage counter with an 8-bit immediate. Relative offsets use sign-magnitude form. Any instruction that is not a branch, and any branch that is not taken, moves on to the next word. The fetch logic feeds it the instruction currently being executed and loads the returned address into its program counter.

Top module: `cobr_branch_unit`

## Requirements
- R1: An instruction whose bits [31:28] are not 8 is not a branch: taken_o is 0 and next_pc_o is pc_i + 1.
- R2: When bits [31:28] = 8, bits [27:25] = 0, bit 21 = 0 and condition bits [24:22] = 0, the jump is taken and next_pc_o equals bits [12:2].
- R3: In an absolute jump with bit 21 = 1, the target is the low PC_W bits of the register whose index is in bits [1:0]. R0 is regs_i[15:0] and Rn is regs_i[16n+15:16n].
- R4: An absolute jump is taken when the condition in bits [24:22] holds. Code 1 needs alu_zero_i = 1, code 2 needs alu_ovf_i = 1, and codes 3 to 7 never take the jump.
- R5: With sub-opcode 1, the immediate is bits [15:0] and R0 is compared unsigned. Bit 16 = 0 takes the branch when R0 < imm, and bit 16 = 1 takes it when R0 >= imm.
- R6: When a relative branch is taken, next_pc_o is pc_i plus the offset, wrapped modulo 2^PC_W. The offset magnitude is bits [23:17] and bit 24 = 1 makes it negative.
- R7: With sub-opcode 2, the immediate is bits [7:0] and the stage counter is compared unsigned. The test in bits [16:15] is 0 for less-than, 1 for greater-or-equal and 2 for less-or-equal. Code 3 never branches.
- R8: When taken_o is 0, next_pc_o is pc_i + 1 and wraps from 2047 to 0.
- R9: A branch with sub-opcode 3 to 7 is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | PC_W | Word address of the current instruction |
| insn_i | input | 32 | Instruction word |
| regs_i | input | REG_N*DATA_W | Register file, R0 in the low slice |
| stage_i | input | STAGE_W | Stage counter value |
| alu_zero_i | input | 1 | Last ALU result was zero |
| alu_ovf_i | input | 1 | Last ALU operation overflowed |
| next_pc_o | output | PC_W | Word address to fetch next |
| taken_o | output | 1 | Branch taken |

## Verification
The checker assumes that the PC, the instruction word and the outputs hold known values. It evaluates its rules only while none of them is X, and this covers the time before the bench first drives the ports. The bench sets every input field on each stimulus, including the register and stage values that an instruction does not use, so no unknown value ever reaches the comparators. The sweeps keep relative offsets within the 7-bit magnitude field. They cover the points where comparisons are close: equal values and values one above or below the immediate.

// File: rtl/cobr_pkg.sv
package cobr_pkg;
  // major opcode and the sub-opcodes that select the branch kind
  localparam logic [3:0] OPC_BRANCH  = 4'd8;
  localparam logic [2:0] KIND_ABS    = 3'd0;
  localparam logic [2:0] KIND_REL_R0 = 3'd1;
  localparam logic [2:0] KIND_REL_SC = 3'd2;

  // absolute jump conditions
  localparam logic [2:0] FLAG_ALWAYS = 3'd0;
  localparam logic [2:0] FLAG_ZERO   = 3'd1;
  localparam logic [2:0] FLAG_OVF    = 3'd2;

  // stage counter tests
  localparam logic [1:0] SC_LT = 2'd0;
  localparam logic [1:0] SC_GE = 2'd1;
  localparam logic [1:0] SC_LE = 2'd2;
endpackage

// File: rtl/cobr_cond.sv
module cobr_cond #(
  parameter int DATA_W  = 16,
  parameter int STAGE_W = 8
) (
  input  logic [DATA_W-1:0]  r0_i,
  input  logic [15:0]        r0_imm_i,
  input  logic               r0_ge_i,
  input  logic [STAGE_W-1:0] stage_i,
  input  logic [7:0]         sc_imm_i,
  input  logic [1:0]         sc_code_i,
  input  logic [2:0]         flag_code_i,
  input  logic               zero_i,
  input  logic               ovf_i,
  output logic               abs_ok_o,
  output logic               r0_ok_o,
  output logic               sc_ok_o
);
  import cobr_pkg::*;

  localparam int RW = (DATA_W > 16) ? DATA_W : 16;
  localparam int SW = (STAGE_W > 8) ? STAGE_W : 8;

  function automatic logic r0_below(input logic [RW-1:0] a, input logic [RW-1:0] b);
    return a < b;
  endfunction

  function automatic logic sc_below(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return a < b;
  endfunction

  logic r0_lt, sc_lt, sc_eq;
  assign r0_lt = r0_below(RW'(r0_i), RW'(r0_imm_i));
  assign sc_lt = sc_below(SW'(stage_i), SW'(sc_imm_i));
  assign sc_eq = (SW'(stage_i) == SW'(sc_imm_i));

  assign r0_ok_o = r0_ge_i ? !r0_lt : r0_lt;

  always_comb begin
    case (sc_code_i)
      SC_LT:   sc_ok_o = sc_lt;
      SC_GE:   sc_ok_o = !sc_lt;
      SC_LE:   sc_ok_o = sc_lt | sc_eq;
      default: sc_ok_o = 1'b0;
    endcase
  end

  always_comb begin
    case (flag_code_i)
      FLAG_ALWAYS: abs_ok_o = 1'b1;
      FLAG_ZERO:   abs_ok_o = zero_i;
      FLAG_OVF:    abs_ok_o = ovf_i;
      default:     abs_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cobr_target.sv
module cobr_target #(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [10:0]       abs_field_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic              use_reg_i,
  input  logic              neg_i,
  input  logic [6:0]        mag_i,
  output logic [PC_W-1:0]   abs_tgt_o,
  output logic [PC_W-1:0]   rel_tgt_o,
  output logic [PC_W-1:0]   seq_pc_o
);
  function automatic logic [PC_W-1:0] rel_step(input logic [PC_W-1:0] base,
                                               input logic neg,
                                               input logic [6:0] mag);
    logic [PC_W-1:0] m;
    m = PC_W'(mag);
    return neg ? (base - m) : (base + m);
  endfunction

  assign seq_pc_o  = pc_i + PC_W'(1);
  assign rel_tgt_o = rel_step(pc_i, neg_i, mag_i);
  assign abs_tgt_o = use_reg_i ? PC_W'(reg_val_i) : PC_W'(abs_field_i);
endmodule

// File: rtl/cobr_branch_unit.sv
module cobr_branch_unit #(
  parameter int PC_W    = 11,
  parameter int DATA_W  = 16,
  parameter int REG_N   = 4,
  parameter int STAGE_W = 8
) (
  input  logic [PC_W-1:0]         pc_i,
  input  logic [31:0]             insn_i,
  input  logic [REG_N*DATA_W-1:0] regs_i,
  input  logic [STAGE_W-1:0]      stage_i,
  input  logic                    alu_zero_i,
  input  logic                    alu_ovf_i,
  output logic [PC_W-1:0]         next_pc_o,
  output logic                    taken_o
);
  import cobr_pkg::*;

  localparam int IDX_W = (REG_N > 1) ? $clog2(REG_N) : 1;

  // register file slices
  logic [DATA_W-1:0] reg_file [REG_N];
  for (genvar g = 0; g < REG_N; g++) begin : g_slice
    assign reg_file[g] = regs_i[g*DATA_W +: DATA_W];
  end

  // decode
  logic is_branch, kind_abs, kind_r0, kind_sc;
  assign is_branch = (insn_i[31:28] == OPC_BRANCH);
  assign kind_abs  = is_branch && (insn_i[27:25] == KIND_ABS);
  assign kind_r0   = is_branch && (insn_i[27:25] == KIND_REL_R0);
  assign kind_sc   = is_branch && (insn_i[27:25] == KIND_REL_SC);

  logic [DATA_W-1:0] reg_sel;
  assign reg_sel = reg_file[insn_i[IDX_W-1:0]];

  // condition evaluation
  logic abs_ok, r0_ok, sc_ok;
  cobr_cond #(.DATA_W(DATA_W), .STAGE_W(STAGE_W)) u_cond (
    .r0_i        (reg_file[0]),
    .r0_imm_i    (insn_i[15:0]),
    .r0_ge_i     (insn_i[16]),
    .stage_i     (stage_i),
    .sc_imm_i    (insn_i[7:0]),
    .sc_code_i   (insn_i[16:15]),
    .flag_code_i (insn_i[24:22]),
    .zero_i      (alu_zero_i),
    .ovf_i       (alu_ovf_i),
    .abs_ok_o    (abs_ok),
    .r0_ok_o     (r0_ok),
    .sc_ok_o     (sc_ok)
  );

  // target arithmetic
  logic [PC_W-1:0] abs_tgt, rel_tgt, seq_pc;
  cobr_target #(.PC_W(PC_W), .DATA_W(DATA_W)) u_tgt (
    .pc_i        (pc_i),
    .abs_field_i (insn_i[12:2]),
    .reg_val_i   (reg_sel),
    .use_reg_i   (insn_i[21]),
    .neg_i       (insn_i[24]),
    .mag_i       (insn_i[23:17]),
    .abs_tgt_o   (abs_tgt),
    .rel_tgt_o   (rel_tgt),
    .seq_pc_o    (seq_pc)
  );

  // named events for the checker
  logic take_abs, take_rel;
  assign take_abs = kind_abs & abs_ok;
  assign take_rel = (kind_r0 & r0_ok) | (kind_sc & sc_ok);

  always_comb begin
    taken_o   = take_abs | take_rel;
    next_pc_o = seq_pc;
    if (take_abs)      next_pc_o = abs_tgt;
    else if (take_rel) next_pc_o = rel_tgt;
  end
endmodule

// File: rtl/cobr_branch_chk.sv
module cobr_branch_chk #(
  parameter int PC_W = 11
) (
  input logic [PC_W-1:0] pc_i,
  input logic [31:0]     insn_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            taken_o,
  input logic            take_rel
);
  logic [PC_W-1:0] step, expect_step;
  assign step        = next_pc_o - pc_i;
  assign expect_step = insn_i[24] ? (PC_W'(0) - PC_W'(insn_i[23:17])) : PC_W'(insn_i[23:17]);

  always_comb begin
    if (!$isunknown({pc_i, insn_i, next_pc_o, taken_o, take_rel})) begin
      // R1
      if (insn_i[31:28] != 4'd8)
        nonbranch_idle_chk: assert (!taken_o);
      // R8
      if (!taken_o)
        seq_pc_chk: assert (step == PC_W'(1));
      // R2
      if (insn_i[31:28] == 4'd8 && insn_i[27:25] == 3'd0 && insn_i[24:22] == 3'd0 && !insn_i[21])
        direct_jump_chk: assert (taken_o && next_pc_o == PC_W'(insn_i[12:2]));
      // R4
      if (insn_i[31:28] == 4'd8 && insn_i[27:25] == 3'd0 && insn_i[24:22] >= 3'd3)
        bad_flag_code_chk: assert (!taken_o);
      // R7
      if (insn_i[31:28] == 4'd8 && insn_i[27:25] == 3'd2 && insn_i[16:15] == 2'd3)
        sc_never_chk: assert (!taken_o);
      // R9
      if (insn_i[31:28] == 4'd8 && insn_i[27:25] >= 3'd3)
        bad_kind_chk: assert (!taken_o);
      // R6
      if (take_rel)
        rel_offset_chk: assert (taken_o && step == expect_step);
    end
  end
endmodule

bind cobr_branch_unit cobr_branch_chk #(.PC_W(PC_W)) u_chk (
  .pc_i      (pc_i),
  .insn_i    (insn_i),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .take_rel  (take_rel)
);

// File: tb/cobr_branch_unit_tb.sv
module cobr_branch_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [10:0] pc_i;
  logic [31:0] insn_i;
  logic [63:0] regs_i;
  logic [7:0]  stage_i;
  logic        alu_zero_i, alu_ovf_i;
  logic [10:0] next_pc_o;
  logic        taken_o;

  cobr_branch_unit u_dut (
    .pc_i(pc_i), .insn_i(insn_i), .regs_i(regs_i), .stage_i(stage_i),
    .alu_zero_i(alu_zero_i), .alu_ovf_i(alu_ovf_i),
    .next_pc_o(next_pc_o), .taken_o(taken_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rv [4];

  function automatic logic [31:0] mk_abs(int cond, int usereg, int addr, int ridx);
    return (32'd8 << 28) | (32'(cond) << 22) | (32'(usereg) << 21) | (32'(addr & 2047) << 2) | 32'(ridx & 3);
  endfunction
  function automatic logic [31:0] mk_r0(int neg, int mag, int ge, int imm);
    return (32'd8 << 28) | (32'd1 << 25) | (32'(neg) << 24) | (32'(mag & 127) << 17) | (32'(ge) << 16) | 32'(imm & 16'hFFFF);
  endfunction
  function automatic logic [31:0] mk_sc(int neg, int mag, int code, int imm);
    return (32'd8 << 28) | (32'd2 << 25) | (32'(neg) << 24) | (32'(mag & 127) << 17) | (32'(code) << 15) | 32'(imm & 255);
  endfunction

  task automatic run(string tag, int pc, logic [31:0] insn, int st, bit z, bit o);
    int exp_nx, op, sub, imm, r0, code, off, cnd;
    bit exp_tk, ok;
    @(negedge clk);
    pc_i = 11'(pc); insn_i = insn; stage_i = 8'(st); alu_zero_i = z; alu_ovf_i = o;
    regs_i = {16'(rv[3]), 16'(rv[2]), 16'(rv[1]), 16'(rv[0])};
    #1;
    op = int'(insn[31:28]); sub = int'(insn[27:25]);
    exp_tk = 0; exp_nx = (pc + 1) % 2048;
    off = insn[24] ? -int'(insn[23:17]) : int'(insn[23:17]);
    if (op == 8) begin
      ok = 0;
      if (sub == 0) begin
        cnd = int'(insn[24:22]);
        ok = (cnd == 0) || (cnd == 1 && z) || (cnd == 2 && o);
        if (ok) begin
          exp_tk = 1;
          exp_nx = insn[21] ? (rv[int'(insn[1:0])] % 2048) : int'(insn[12:2]);
        end
      end else if (sub == 1 || sub == 2) begin
        if (sub == 1) begin
          imm = int'(insn[15:0]); r0 = rv[0];
          ok = insn[16] ? (r0 >= imm) : (r0 < imm);
        end else begin
          imm = int'(insn[7:0]); code = int'(insn[16:15]);
          ok = (code == 0) ? (st < imm) : (code == 1) ? (st >= imm) : (code == 2) ? (st <= imm) : 1'b0;
        end
        if (ok) begin
          exp_tk = 1;
          exp_nx = (pc + off + 4096) % 2048;
        end
      end
    end
    checks++;
    if (taken_o !== exp_tk || int'(next_pc_o) != exp_nx || $isunknown(next_pc_o)) begin
      errors++;
      $display("FAIL %s: taken=%0b next=%0d expected taken=%0b next=%0d (insn=%h pc=%0d)",
               tag, taken_o, next_pc_o, exp_tk, exp_nx, insn, pc);
    end
  endtask

  initial begin
    rv[0] = 0; rv[1] = 0; rv[2] = 0; rv[3] = 0;
    // all-zero inputs: opcode 0 is not a branch (R1)
    run("R1", 0, 32'h0, 0, 0, 0);
    // R1: every other opcode
    for (int op = 0; op < 16; op++)
      if (op != 8) run("R1", 100 + op, (32'(op) << 28) | 32'h0000_1234, 7, 1, 1);
    // R8: wrap of the sequential address
    run("R8", 2047, 32'h1000_0000, 0, 0, 0);
    run("R8", 2047, mk_abs(1, 0, 5, 0), 0, 0, 0);
    // R2 / R4: all condition codes against all flag pairs
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 4; f++) begin
        run("R4", 300, mk_abs(c, 0, 1234 + c, 0), 0, f[0], f[1]);
        run("R2", 2047, mk_abs(0, 0, (c * 293) % 2048, 0), 0, f[0], f[1]);
      end
    // R3: register targets, including values beyond the address space
    rv[0] = 16'h0012; rv[1] = 16'h07FF; rv[2] = 16'hF805; rv[3] = 16'h0800;
    for (int r = 0; r < 4; r++) begin
      run("R3", 50, mk_abs(0, 1, 999, r), 0, 0, 0);
      run("R3", 50, mk_abs(1, 1, 999, r), 0, 1, 0);
    end
    // R5: R0 against immediates around the comparison edge
    foreach (rv[i]) rv[i] = 0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int ge = 0; ge < 2; ge++) begin
          int vals [7] = '{0, 1, 2, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
          rv[0] = vals[a];
          run("R5", 1000, mk_r0(a % 2, 3 + b, ge, vals[b]), 0, 0, 0);
        end
    // R6: every magnitude, both signs, near both ends of the space
    rv[0] = 0;
    for (int m = 0; m < 128; m++)
      for (int s = 0; s < 2; s++) begin
        run("R6", 5, mk_r0(s, m, 0, 1), 0, 0, 0);
        run("R6", 2040, mk_sc(s, m, 1, 0), 9, 0, 0);
      end
    // R7: full stage sweep for every test code and a few immediates
    for (int st = 0; st < 256; st++)
      for (int code = 0; code < 4; code++) begin
        int imms [3] = '{0, 77, 255};
        foreach (imms[k]) run("R7", 640, mk_sc(code % 2, 9, code, imms[k]), st, 1, 1);
      end
    // R9: unused sub-opcodes
    for (int sub = 3; sub < 8; sub++)
      run("R9", 222, (32'd8 << 28) | (32'(sub) << 25), 0, 1, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule